// File: doc/BRIEF.md
# SDRAM Open-Page Tracker

This block sits in front of an SDRAM command scheduler and keeps track of which banks currently hold an open page. Every page that is open shares one tracked row address, so up to four banks can be open at a time and all of them hold the same row. Each accepted request carries a bank index, a row address and a read/write flag. The block classifies the request as a page hit, a bank-empty case or a page miss. It then emits the precharge, activate and column commands that serve the request, spaced by the row-precharge and row-to-column gaps.

A configuration input chooses how a miss closes pages. When it is low, the block issues one single-bank precharge for each open bank. The addressed bank goes first, and the others follow in ascending index order. When it is high, one precharge-all command closes every bank. A miss always ends with no bank open, because a new row may not coexist with the old one. Requests use a valid/ready handshake. The block also reports the classification of every accepted request on a one-cycle result strobe.

Top module: `sdram_page_tracker`

## Requirements
- R1: Each accepted request (`req_valid` and `req_ready` high at a rising edge) produces `res_valid` high for exactly the following cycle. In that cycle `res_kind` is 1 for a hit, 2 for bank-empty and 3 for a miss, and the first command of the request is shown in the same cycle.
- R2: Up to four banks may be open at once, and all open banks share one tracked row. The first activate after all banks are closed sets the tracked row. Once the last open bank is precharged, the tracked row becomes invalid.
- R3: A hit is a request whose bank is open and whose row equals the tracked row. It issues only the column command in the cycle after acceptance, and `req_ready` stays high.
- R4: A bank-empty request targets a closed bank while no bank is open or the row equals the tracked row. It issues an activate in the cycle after acceptance and the column command exactly T_RCD cycles later, with NOP in between.
- R5: With `cfg_close_all` high at acceptance, a miss issues one precharge-all. An activate to the requested bank and row follows exactly T_RP cycles later, and the column command follows T_RCD cycles after that.
- R6: With `cfg_close_all` low at acceptance, a miss issues one single-bank precharge per open bank on consecutive cycles. The addressed bank goes first if it is open, then the others in ascending index order. The activate follows T_RP cycles after the last precharge.
- R7: A request to a closed bank whose row differs from the valid tracked row is a miss. It closes every open bank before it activates.
- R8: `req_ready` is low from the cycle after a non-hit request is accepted until the cycle in which its column command appears, when it is high again. `req_valid` and the request fields are ignored while `req_ready` is low.
- R9: `cmd_code` encodes 0 NOP, 1 single-bank precharge, 2 precharge-all, 3 activate and 4 column read/write. `cmd_bank` is valid for codes 1, 3 and 4. `cmd_row` is valid for codes 3 and 4. `cmd_write` is valid for code 4.
- R10: After reset, no bank is open, `cmd_code` is NOP, `res_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_close_all | input | 1 | Miss policy: 0 per-bank precharge, 1 precharge-all |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_bank | input | BANK_W (2) | Target bank index |
| req_row | input | ROW_W (12) | Target row address |
| req_write | input | 1 | 1 write, 0 read |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_bank | output | BANK_W (2) | Bank of the command |
| cmd_row | output | ROW_W (12) | Row of an activate or column command |
| cmd_write | output | 1 | Direction of a column command |
| res_valid | output | 1 | One-cycle classification strobe |
| res_kind | output | 2 | 1 hit, 2 empty, 3 miss |

## Verification
The bench builds its own page model and aims at the points where the single-row rule and the policy bit interact. One case is a closed bank requested with a different row while other banks are open. A design that checked only the addressed bank would activate there and leave two rows open. Other cases are a per-bank miss whose target is open and one whose target is closed. There, a wrong victim order or a dropped precharge shows up directly in the command stream. The bench also asserts junk requests while the block is busy and counts the exact NOP gaps. A design that accepted during a sequence, or miscounted T_RP or T_RCD, would issue commands in the wrong cycles.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PRE    = 3'd1,
    CMD_PREALL = 3'd2,
    CMD_ACT    = 3'd3,
    CMD_RW     = 3'd4
  } sdcmd_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_EMPTY = 2'd2,
    RES_MISS  = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE_SEQ,
    ST_PRE_WAIT,
    ST_ACT_WAIT
  } seq_st_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spt_bank_table.sv
module spt_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [BANK_W-1:0]    set_bank,
  input  logic [ROW_W-1:0]     set_row,
  input  logic                 clr_one,
  input  logic [BANK_W-1:0]    clr_bank,
  input  logic                 clr_all,
  output logic [NUM_BANKS-1:0] open_mask,
  output logic                 row_valid,
  output logic [ROW_W-1:0]     trk_row
);

  logic [NUM_BANKS-1:0] left_after_clr;
  logic                 last_closing;

  assign left_after_clr = open_mask & ~(NUM_BANKS'(1) << clr_bank);
  assign last_closing   = clr_all || (clr_one && (left_after_clr == '0));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                  open_mask[g] <= 1'b0;
      else if (clr_all)                            open_mask[g] <= 1'b0;
      else if (clr_one && clr_bank == BANK_W'(g))  open_mask[g] <= 1'b0;
      else if (set_en && set_bank == BANK_W'(g))   open_mask[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      trk_row   <= '0;
    end else if (set_en) begin
      row_valid <= 1'b1;
      trk_row   <= set_row;
    end else if (last_closing) begin
      row_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/spt_classifier.sv
module spt_classifier #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0] open_mask,
  input  logic                 row_valid,
  input  logic [ROW_W-1:0]     trk_row,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_row,
  output logic                 is_hit,
  output logic                 is_empty,
  output logic                 is_miss
);

  function automatic logic same_row(input logic vld, input logic [ROW_W-1:0] a,
                                    input logic [ROW_W-1:0] b);
    return vld && (a == b);
  endfunction

  logic bank_open;
  logic row_eq;

  assign bank_open = open_mask[req_bank];
  assign row_eq    = same_row(row_valid, trk_row, req_row);

  always_comb begin
    is_hit   = bank_open && row_eq;
    is_empty = !bank_open && (!row_valid || row_eq);
    is_miss  = !is_hit && !is_empty;
  end

endmodule

// File: rtl/spt_cmd_seq.sv
module spt_cmd_seq
  import spt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(max_u(T_RP, T_RCD) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_fire,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_row,
  input  logic                 req_write,
  input  logic                 cfg_close_all,
  input  logic                 is_hit,
  input  logic                 is_empty,
  input  logic [NUM_BANKS-1:0] open_mask,
  output logic                 busy,
  output sdcmd_e               cmd_q,
  output logic [BANK_W-1:0]    cmd_bank_q,
  output logic [ROW_W-1:0]     cmd_row_q,
  output logic                 cmd_write_q,
  output logic                 res_valid_q,
  output res_e                 res_kind_q,
  output logic                 set_en,
  output logic [BANK_W-1:0]    set_bank,
  output logic [ROW_W-1:0]     set_row,
  output logic                 clr_one,
  output logic [BANK_W-1:0]    clr_bank,
  output logic                 clr_all
);

  // Victim choice: target bank if open, otherwise the lowest open bank.
  function automatic logic [BANK_W-1:0] pick_victim(input logic [NUM_BANKS-1:0] mask,
                                                    input logic [BANK_W-1:0] target);
    logic [BANK_W-1:0] pick;
    pick = target;
    if (!mask[target]) begin
      for (int i = NUM_BANKS - 1; i >= 0; i--)
        if (mask[i]) pick = BANK_W'(i);
    end
    return pick;
  endfunction

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BANK_W-1:0] l_bank;
  logic [ROW_W-1:0]  l_row;
  logic              l_write;
  logic              l_pol;

  logic [BANK_W-1:0] op_bank;
  logic [ROW_W-1:0]  op_row;
  logic              op_write;
  logic [BANK_W-1:0] victim;
  logic              victim_last;

  sdcmd_e            cmd_d;
  logic [BANK_W-1:0] cmd_bank_d;
  logic [ROW_W-1:0]  cmd_row_d;
  logic              cmd_write_d;
  logic              res_valid_d;
  res_e              res_kind_d;

  assign op_bank     = (st_q == ST_IDLE) ? req_bank  : l_bank;
  assign op_row      = (st_q == ST_IDLE) ? req_row   : l_row;
  assign op_write    = (st_q == ST_IDLE) ? req_write : l_write;
  assign victim      = pick_victim(open_mask, op_bank);
  assign victim_last = (open_mask & ~(NUM_BANKS'(1) << victim)) == '0;
  assign busy        = (st_q != ST_IDLE);

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    cmd_d       = CMD_NOP;
    cmd_bank_d  = cmd_bank_q;
    cmd_row_d   = cmd_row_q;
    cmd_write_d = cmd_write_q;
    res_valid_d = 1'b0;
    res_kind_d  = RES_NONE;
    set_en      = 1'b0;
    set_bank    = op_bank;
    set_row     = op_row;
    clr_one     = 1'b0;
    clr_bank    = victim;
    clr_all     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (req_fire) begin
          res_valid_d = 1'b1;
          cmd_bank_d  = op_bank;
          cmd_row_d   = op_row;
          cmd_write_d = op_write;
          if (is_hit) begin
            res_kind_d = RES_HIT;
            cmd_d      = CMD_RW;
          end else if (is_empty) begin
            res_kind_d = RES_EMPTY;
            cmd_d      = CMD_ACT;
            set_en     = 1'b1;
            st_d       = ST_ACT_WAIT;
            cnt_d      = CNT_W'(T_RCD - 1);
          end else begin
            res_kind_d = RES_MISS;
            if (cfg_close_all) begin
              cmd_d   = CMD_PREALL;
              clr_all = 1'b1;
              st_d    = ST_PRE_WAIT;
              cnt_d   = CNT_W'(T_RP - 1);
            end else begin
              cmd_d      = CMD_PRE;
              cmd_bank_d = victim;
              clr_one    = 1'b1;
              st_d       = victim_last ? ST_PRE_WAIT : ST_PRE_SEQ;
              cnt_d      = CNT_W'(T_RP - 1);
            end
          end
        end
      end
      ST_PRE_SEQ: begin
        cmd_d      = CMD_PRE;
        cmd_bank_d = victim;
        clr_one    = 1'b1;
        st_d       = victim_last ? ST_PRE_WAIT : ST_PRE_SEQ;
        cnt_d      = CNT_W'(T_RP - 1);
      end
      ST_PRE_WAIT: begin
        if (cnt_q == '0) begin
          cmd_d      = CMD_ACT;
          cmd_bank_d = op_bank;
          cmd_row_d  = op_row;
          set_en     = 1'b1;
          st_d       = ST_ACT_WAIT;
          cnt_d      = CNT_W'(T_RCD - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACT_WAIT: begin
        if (cnt_q == '0) begin
          cmd_d       = CMD_RW;
          cmd_bank_d  = op_bank;
          cmd_row_d   = op_row;
          cmd_write_d = op_write;
          st_d        = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      l_bank      <= '0;
      l_row       <= '0;
      l_write     <= 1'b0;
      l_pol       <= 1'b0;
      cmd_q       <= CMD_NOP;
      cmd_bank_q  <= '0;
      cmd_row_q   <= '0;
      cmd_write_q <= 1'b0;
      res_valid_q <= 1'b0;
      res_kind_q  <= RES_NONE;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      cmd_q       <= cmd_d;
      cmd_bank_q  <= cmd_bank_d;
      cmd_row_q   <= cmd_row_d;
      cmd_write_q <= cmd_write_d;
      res_valid_q <= res_valid_d;
      res_kind_q  <= res_kind_d;
      if (req_fire) begin
        l_bank  <= req_bank;
        l_row   <= req_row;
        l_write <= req_write;
        l_pol   <= cfg_close_all;
      end
    end
  end

  // The latched policy is kept for observation; the policy only matters at acceptance.
  logic unused_pol;
  assign unused_pol = l_pol;

endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
  import spt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_close_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              cmd_write,
  output logic              res_valid,
  output logic [1:0]        res_kind
);

  // Named internal events, brought out for the checker.
  logic [NUM_BANKS-1:0] open_mask;
  logic                 row_valid;
  logic [ROW_W-1:0]     trk_row;
  logic                 is_hit, is_empty, is_miss;
  logic                 busy;
  logic                 req_fire;
  logic                 set_en, clr_one, clr_all;
  logic [BANK_W-1:0]    set_bank, clr_bank;
  logic [ROW_W-1:0]     set_row;
  sdcmd_e               cmd_e;
  res_e                 res_e_q;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;

  spt_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_bank(set_bank), .set_row(set_row),
    .clr_one(clr_one), .clr_bank(clr_bank), .clr_all(clr_all),
    .open_mask(open_mask), .row_valid(row_valid), .trk_row(trk_row)
  );

  spt_classifier #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) class_i (
    .open_mask(open_mask), .row_valid(row_valid), .trk_row(trk_row),
    .req_bank(req_bank), .req_row(req_row),
    .is_hit(is_hit), .is_empty(is_empty), .is_miss(is_miss)
  );

  spt_cmd_seq #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_fire(req_fire), .req_bank(req_bank), .req_row(req_row), .req_write(req_write),
    .cfg_close_all(cfg_close_all), .is_hit(is_hit), .is_empty(is_empty),
    .open_mask(open_mask), .busy(busy),
    .cmd_q(cmd_e), .cmd_bank_q(cmd_bank), .cmd_row_q(cmd_row), .cmd_write_q(cmd_write),
    .res_valid_q(res_valid), .res_kind_q(res_e_q),
    .set_en(set_en), .set_bank(set_bank), .set_row(set_row),
    .clr_one(clr_one), .clr_bank(clr_bank), .clr_all(clr_all)
  );

  assign cmd_code = cmd_e;
  assign res_kind = res_e_q;

  logic unused_miss;
  assign unused_miss = is_miss;

endmodule

// File: rtl/spt_checks.sv
module spt_checks #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic [2:0]           cmd_code,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 res_valid,
  input logic [1:0]           res_kind,
  input logic [NUM_BANKS-1:0] open_mask,
  input logic                 row_valid,
  input logic [ROW_W-1:0]     trk_row
);

  p_row_follows_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid == (open_mask != '0));

  p_row_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && $past(row_valid)) |-> $stable(trk_row));

  p_hit_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd1) |-> (cmd_code == 3'd4 && req_ready));

  p_empty_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2) |-> (cmd_code == 3'd3));

  p_miss_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd3) |-> (cmd_code == 3'd1 || cmd_code == 3'd2));

  p_preall_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd2) |-> (open_mask == '0));

  p_act_marks_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd3) |-> open_mask[cmd_bank]);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd1 || cmd_code == 3'd2 || cmd_code == 3'd3) |-> !req_ready);

endmodule

bind sdram_page_tracker spt_checks #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .res_valid(res_valid), .res_kind(res_kind),
  .open_mask(open_mask), .row_valid(row_valid), .trk_row(trk_row)
);

// File: tb/sdram_page_tracker_tb.sv
module sdram_page_tracker_tb_top;

  localparam int NB   = 4;
  localparam int RW   = 12;
  localparam int TRP  = 2;
  localparam int TRCD = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_close_all = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic          req_write = 1'b0;
  logic [2:0]    cmd_code;
  logic [1:0]    cmd_bank;
  logic [RW-1:0] cmd_row;
  logic          cmd_write;
  logic          res_valid;
  logic [1:0]    res_kind;

  int checks = 0;
  int fails  = 0;

  // Bench page model
  bit      open_m[NB];
  bit      vld_m;
  int      row_m;
  int      exp_cmd[16];
  int      exp_bank[16];
  int      n_exp;

  always #2 clk = ~clk;

  sdram_page_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .T_RP(TRP), .T_RCD(TRCD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_close_all(cfg_close_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_write(req_write), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_write(cmd_write),
    .res_valid(res_valid), .res_kind(res_kind)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add(input int c, input int b);
    exp_cmd[n_exp]  = c;
    exp_bank[n_exp] = b;
    n_exp++;
  endtask

  // Expected command list from the requirements; updates the model.
  task automatic build(input int bank, input int row, input bit pol, output int kind);
    n_exp = 0;
    if (open_m[bank] && vld_m && row == row_m) begin
      kind = 1;
      add(4, bank);
    end else begin
      if (!open_m[bank] && (!vld_m || row == row_m)) kind = 2;
      else begin
        kind = 3;
        if (pol) add(2, 0);
        else begin
          if (open_m[bank]) begin add(1, bank); open_m[bank] = 0; end
          for (int b = 0; b < NB; b++)
            if (open_m[b]) begin add(1, b); open_m[b] = 0; end
        end
        for (int b = 0; b < NB; b++) open_m[b] = 0;
        vld_m = 0;
        for (int i = 0; i < TRP - 1; i++) add(0, 0);
      end
      add(3, bank);
      open_m[bank] = 1;
      vld_m = 1;
      row_m = row;
      for (int i = 0; i < TRCD - 1; i++) add(0, 0);
      add(4, bank);
    end
  endtask

  // One request; junk=1 keeps valid high with other fields while busy (R8).
  task automatic do_req(input int bank, input int row, input bit wr, input bit pol,
                        input bit junk, input string tag);
    int kind;
    build(bank, row, pol, kind);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
    cfg_close_all = pol;
    req_valid = 1'b1;
    req_bank  = 2'(bank);
    req_row   = RW'(row);
    req_write = wr;
    @(posedge clk);
    for (int i = 0; i < n_exp; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(res_valid == 1'b1, "R1", "res_valid", int'(res_valid), 1);
        chk(int'(res_kind) == kind, "R1", "res_kind", int'(res_kind), kind);
      end else begin
        chk(res_valid == 1'b0, "R1", "res_valid pulse", int'(res_valid), 0);
      end
      chk(int'(cmd_code) == exp_cmd[i], tag, "cmd_code", int'(cmd_code), exp_cmd[i]);
      if (exp_cmd[i] == 1 || exp_cmd[i] == 3 || exp_cmd[i] == 4)
        chk(int'(cmd_bank) == exp_bank[i], tag, "cmd_bank", int'(cmd_bank), exp_bank[i]);
      if (exp_cmd[i] == 3 || exp_cmd[i] == 4)
        chk(int'(cmd_row) == row, "R9", "cmd_row", int'(cmd_row), row);
      if (exp_cmd[i] == 4)
        chk(cmd_write == wr, "R9", "cmd_write", int'(cmd_write), int'(wr));
      chk(req_ready == (i == n_exp - 1), "R8", "ready during sequence",
          int'(req_ready), int'(i == n_exp - 1));
      if (junk && i < n_exp - 1) begin
        req_valid = 1'b1;
        req_bank  = 2'(bank + 1);
        req_row   = RW'(row ^ 12'h0F0);
        cfg_close_all = ~pol;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(cmd_code == 3'd0, tag, "idle after request", int'(cmd_code), 0);
  endtask

  task automatic t_reset();
    // R10: reset state
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    chk(cmd_code == 3'd0, "R10", "cmd after reset", int'(cmd_code), 0);
    chk(res_valid == 1'b0, "R10", "res_valid after reset", int'(res_valid), 0);
  endtask

  task automatic t_empty_then_hit();
    do_req(1, 12'h055, 1'b0, 1'b0, 1'b0, "R4");
    do_req(1, 12'h055, 1'b1, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_four_open();
    // R2: all four banks open on the same row, each then a hit
    do_req(2, 12'h055, 1'b1, 1'b0, 1'b0, "R2");
    do_req(0, 12'h055, 1'b0, 1'b1, 1'b0, "R2");
    do_req(3, 12'h055, 1'b0, 1'b0, 1'b0, "R2");
    for (int b = 0; b < NB; b++) do_req(b, 12'h055, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_miss_per_bank();
    // R6: target open, four victims, target first then ascending
    do_req(2, 12'h3A1, 1'b1, 1'b0, 1'b0, "R6");
    do_req(2, 12'h3A1, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_closed_bank_other_row();
    // R7 and R5: closed bank, different row, precharge-all
    do_req(0, 12'h7E0, 1'b0, 1'b1, 1'b0, "R7");
    do_req(3, 12'h7E0, 1'b1, 1'b0, 1'b0, "R4");
    // R6: target closed, victims in ascending order
    do_req(1, 12'h123, 1'b0, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_preall_open_target();
    do_req(2, 12'h123, 1'b0, 1'b0, 1'b0, "R4");
    do_req(1, 12'hABC, 1'b1, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_busy_ignored();
    // R8: junk requests while busy are not taken; state shows it at the ports
    do_req(0, 12'h444, 1'b0, 1'b0, 1'b1, "R8");
    do_req(0, 12'h444, 1'b1, 1'b0, 1'b0, "R8");
    do_req(1, 12'h444, 1'b0, 1'b1, 1'b1, "R8");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) open_m[b] = 0;
    vld_m = 0;
    row_m = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty_then_hit();
    t_four_open();
    t_miss_per_bank();
    t_closed_bank_other_row();
    t_preall_open_target();
    t_busy_ignored();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule